// File: doc/BRIEF.md
# Windowed Copy Address Generator

This block produces the byte addresses for both sides of a memory copy. Each side keeps a base address and an offset counter. The address it presents is base plus offset. Each time one byte moves, a shared advance strobe steps both sides by one.

A side runs in one of two ways. In linear mode its address climbs without limit, wrapping only at the top of the address space. In windowed mode its offset wraps inside a power-of-two window of 1, 2, 4 or 8 bytes. The window is measured from the loaded base and not from an aligned boundary. This suits a device port that behaves like a small FIFO or a fixed register.

One mode word configures both sides. Each side reads its own enable bit and its own two-bit log2 size field from that word. A load strobe on a side takes a new base and clears that side's offset.

Top module: `hla_copy_addr`

## Requirements
- R1: While `rst_n` is low, both address outputs read zero, whatever the other inputs do.
- R2: When a side's load strobe is high at a rising clock edge, that side's address equals the presented base right after that edge, with the offset cleared.
- R3: With a side's enable bit clear, each advance without a load raises that side's address by exactly one.
- R4: With a side's enable bit set and size field value f, the offset runs 0, 1 ... 2^f−1 and then returns to 0. The offset never exceeds 2^f−1 after an advance.
- R5: With the enable bit set and a size field of 0, the address stays at the base on every advance.
- R6: The window is counted from the loaded base, even when that base is not aligned. A base of 0x3003 with size 4 gives 0x3003, 0x3004, 0x3005, 0x3006, 0x3003.
- R7: If load and advance are both high in the same cycle, the load wins and the address becomes the new base.
- R8: With neither load nor advance high, a side's address does not change, even if the mode word changes.
- R9: The source side takes its enable from mode bit 12 and its size from bits 15:14. The destination side takes its enable from bit 13 and its size from bits 17:16. A field of one side has no effect on the other side.
- R10: In linear mode the address wraps modulo 2^ADDR_W. An advance from all-ones gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | MODE_W | Holds both sides' enable bits and size fields |
| src_base | input | ADDR_W | Base address loaded into the source side |
| src_load | input | 1 | Load strobe for the source base |
| dst_base | input | ADDR_W | Base address loaded into the destination side |
| dst_load | input | 1 | Load strobe for the destination base |
| byte_adv | input | 1 | One-byte advance, applied to both sides |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |

## Verification
A base load and a byte advance can arrive on the same edge. The bench provokes this on the source side while the destination side advances alone in that same cycle. It then expects the source address to equal the new base and the destination address to step by one. A second clash is a mode change that arrives together with an advance. Here the new window has to apply to that very step, which is judged by checking the masked offset in the cycle right after the change.

// File: rtl/hla_pkg.sv
package hla_pkg;

    // Mode word bit positions for each side.
    localparam int SRC_EN_BIT = 12;
    localparam int DST_EN_BIT = 13;
    localparam int SRC_SZ_LSB = 14;
    localparam int DST_SZ_LSB = 16;
    localparam int SZ_W       = 2;
    localparam int NUM_SIDES  = 2;

    typedef struct packed {
        logic            wrap_en;
        logic [SZ_W-1:0] log2_sz;
    } hold_cfg_t;

endpackage

// File: rtl/hla_mode_tap.sv
module hla_mode_tap
    import hla_pkg::*;
#(
    parameter int MODE_W = 32,
    parameter int EN_BIT = 12,
    parameter int SZ_LSB = 14
) (
    input  logic [MODE_W-1:0] mode_word,
    output hold_cfg_t         cfg
);
    always_comb begin
        cfg.wrap_en = mode_word[EN_BIT];
        cfg.log2_sz = mode_word[SZ_LSB +: SZ_W];
    end
endmodule

// File: rtl/hla_window_mask.sv
module hla_window_mask
    import hla_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  hold_cfg_t        cfg,
    output logic [OFF_W-1:0] mask
);
    always_comb begin
        if (cfg.wrap_en) begin
            mask = (OFF_W'(1) << cfg.log2_sz) - OFF_W'(1);
        end else begin
            mask = '1;
        end
    end
endmodule

// File: rtl/hla_side_gen.sv
module hla_side_gen
    import hla_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 32,
    parameter int EN_BIT = 12,
    parameter int SZ_LSB = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              load,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] off;
    } side_st_t;

    hold_cfg_t         cfg;
    logic [ADDR_W-1:0] mask;
    side_st_t          st_d, st_q;

    hla_mode_tap #(
        .MODE_W(MODE_W),
        .EN_BIT(EN_BIT),
        .SZ_LSB(SZ_LSB)
    ) tap_i (
        .mode_word(mode_word),
        .cfg      (cfg)
    );

    hla_window_mask #(
        .OFF_W(ADDR_W)
    ) mask_i (
        .cfg (cfg),
        .mask(mask)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = base_in;
            st_d.off  = '0;
        end else if (adv) begin
            // The mask is all ones in linear mode, so the step is a plain increment.
            st_d.off = (st_q.off + ADDR_W'(1)) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.base + st_q.off;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(base_in));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && !cfg.wrap_en) |=> addr == $past(addr) + ADDR_W'(1));

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && cfg.wrap_en) |=> st_q.off <= $past(mask));

    assert_single_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && cfg.wrap_en && cfg.log2_sz == '0) |=> addr == $past(st_q.base));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(addr));

endmodule

// File: rtl/hla_copy_addr.sv
module hla_copy_addr
    import hla_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic              src_load,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              dst_load,
    input  logic              byte_adv,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    logic [NUM_SIDES-1:0][ADDR_W-1:0] base_v;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_SIDES-1:0]             load_v;

    assign base_v = {dst_base, src_base};
    assign load_v = {dst_load, src_load};

    // Side 0 is the source side and side 1 is the destination side.
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        hla_side_gen #(
            .ADDR_W(ADDR_W),
            .MODE_W(MODE_W),
            .EN_BIT((s == 0) ? SRC_EN_BIT : DST_EN_BIT),
            .SZ_LSB((s == 0) ? SRC_SZ_LSB : DST_SZ_LSB)
        ) side_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_word(mode_word),
            .base_in  (base_v[s]),
            .load     (load_v[s]),
            .adv      (byte_adv),
            .addr     (addr_v[s])
        );
    end

    assign src_addr = addr_v[0];
    assign dst_addr = addr_v[1];

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (src_addr == '0 && dst_addr == '0));

endmodule

// File: tb/hla_copy_addr_tb_top.sv
module hla_copy_addr_tb_top;
    localparam int AW = 32;

    typedef struct packed {
        logic [7:0]    req;
        logic [31:0]   mode;
        logic          sl;
        logic [AW-1:0] sb;
        logic          dl;
        logic [AW-1:0] db;
        logic          adv;
        logic [AW-1:0] es;
        logic [AW-1:0] ed;
    } vec_t;

    localparam int NV = 23;
    // Mode encodings: bit 12 is the source enable, bits 15:14 the source log2 size,
    // bit 13 the destination enable, bits 17:16 the destination log2 size (R9).
    localparam vec_t VEC [NV] = '{
        '{8'd2,  32'h0,     1'b1, 32'h1000,     1'b1, 32'h2000,     1'b0, 32'h1000,     32'h2000},     // R2
        '{8'd3,  32'h0,     1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h1001,     32'h2001},     // R3
        '{8'd3,  32'h0,     1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h1002,     32'h2002},     // R3
        '{8'd4,  32'h9000,  1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h1003,     32'h2003},     // R4
        '{8'd4,  32'h9000,  1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h1000,     32'h2004},     // R4
        '{8'd4,  32'h9000,  1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h1001,     32'h2005},     // R4
        '{8'd8,  32'h9000,  1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 32'h1001,     32'h2005},     // R8
        '{8'd2,  32'h1B000, 1'b1, 32'h3003,     1'b1, 32'h4000,     1'b0, 32'h3003,     32'h4000},     // R2
        '{8'd6,  32'h1B000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3004,     32'h4001},     // R6
        '{8'd6,  32'h1B000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3005,     32'h4000},     // R6
        '{8'd6,  32'h1B000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3006,     32'h4001},     // R6
        '{8'd6,  32'h1B000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3003,     32'h4000},     // R6
        '{8'd5,  32'h33000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3003,     32'h4001},     // R5
        '{8'd5,  32'h33000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h3003,     32'h4002},     // R5
        '{8'd7,  32'h33000, 1'b1, 32'h5000,     1'b0, 32'h0,        1'b1, 32'h5000,     32'h4003},     // R7
        '{8'd3,  32'h0,     1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h5001,     32'h4004},     // R3
        '{8'd2,  32'h0,     1'b1, 32'hFFFFFFFE, 1'b1, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFE, 32'hFFFFFFFF}, // R2
        '{8'd10, 32'h0,     1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'hFFFFFFFF, 32'h0},        // R10
        '{8'd10, 32'h0,     1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h0,        32'h1},        // R10
        '{8'd9,  32'h35000, 1'b1, 32'h100,      1'b1, 32'h200,      1'b0, 32'h100,      32'h200},      // R9
        '{8'd9,  32'h35000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h101,      32'h201},      // R9
        '{8'd9,  32'h35000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h100,      32'h202},      // R9
        '{8'd9,  32'h35000, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 32'h101,      32'h203}       // R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   mode_word = '0;
    logic [AW-1:0] src_base = '0;
    logic          src_load = 1'b0;
    logic [AW-1:0] dst_base = '0;
    logic          dst_load = 1'b0;
    logic          byte_adv = 1'b0;
    logic [AW-1:0] src_addr, dst_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hla_copy_addr #(.ADDR_W(AW), .MODE_W(32)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_word(mode_word),
        .src_base (src_base),
        .src_load (src_load),
        .dst_base (dst_base),
        .dst_load (dst_load),
        .byte_adv (byte_adv),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    task automatic check(input int req, input logic [AW-1:0] es, input logic [AW-1:0] ed);
        n_chk++;
        if (src_addr !== es || dst_addr !== ed) begin
            n_bad++;
            $display("FAIL R%0d: src=%h dst=%h expected src=%h dst=%h",
                     req, src_addr, dst_addr, es, ed);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: loads and advances during reset must leave both outputs at zero.
        src_load = 1'b1; dst_load = 1'b1; byte_adv = 1'b1;
        src_base = 32'hABCD; dst_base = 32'h1234;
        repeat (3) @(negedge clk);
        check(1, '0, '0);
        src_load = 1'b0; dst_load = 1'b0; byte_adv = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(8, '0, '0);

        for (int i = 0; i < NV; i++) begin
            mode_word = VEC[i].mode;
            src_load  = VEC[i].sl;
            src_base  = VEC[i].sb;
            dst_load  = VEC[i].dl;
            dst_base  = VEC[i].db;
            byte_adv  = VEC[i].adv;
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].es, VEC[i].ed);
        end

        // R1: reset in mid-run clears both sides at once.
        src_load = 1'b0; dst_load = 1'b0; byte_adv = 1'b1;
        rst_n = 1'b0;
        #1;
        check(1, '0, '0);
        @(negedge clk);
        check(1, '0, '0);
        rst_n = 1'b1;
        // R3: after reset, linear stepping starts from zero.
        mode_word = '0;
        @(negedge clk);
        check(3, 32'h1, 32'h1);

        // R5: a single-byte window on both sides holds the loaded base.
        mode_word = 32'h3000;
        src_load = 1'b1; src_base = 32'h77; dst_load = 1'b1; dst_base = 32'h88;
        byte_adv = 1'b0;
        @(negedge clk);
        src_load = 1'b0; dst_load = 1'b0; byte_adv = 1'b1;
        repeat (3) @(negedge clk);
        check(5, 32'h77, 32'h88);
        byte_adv = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule